// File: doc/BRIEF.md
# Interrupt Controller with Sleep Wake-up

This block gathers the interrupt events of a small 8-bit microcontroller core. Eight sources are handled: an external pin with a selectable active edge, a timer-0 overflow, a port-change event, two comparator events, a timer-1 overflow, a data-EEPROM write completion and a clock-monitor failure. Every source has a sticky flag and an individual enable. A global enable gates the request to the core. The core reads and writes these bits through four registers selected by a two-bit address.

The core gets a request line and a fixed vector address. It tells the block when it takes an interrupt, which clears the global enable, and when it returns from one, which sets the global enable again. While the core is asleep, a wake line rises as soon as an enabled flag is pending, whatever the state of the global enable. The core then decides from the global enable whether to branch to the vector or to carry on in sequence.

Top module: `intc_top`

## Requirements
- R1: After a synchronous reset, `irq_o`, `wake_o` and `rd_o` are 0. Every flag, enable and the global enable are 0. The edge-select bit is 1, so register 0 reads 0x00 and register 3 reads 0x40.
- R2: An event pulse sets its flag at the next rising clock edge, even when its enable or the global enable is clear. Register 0 holds the port-change flag in bit 0, the pin flag in bit 1 and the timer-0 flag in bit 2. Registers 1 (flags) and 2 (enables) use bit 0 for comparator 0, bit 1 for comparator 1, bit 2 for timer-1, bit 3 for EEPROM write completion and bit 4 for clock failure. Unused bits read 0.
- R3: A flag stays set until software writes 0 into it. When an event and a software clear of the same flag fall in one cycle, the flag ends up set.
- R4: At every rising edge `irq_o` is updated to the global enable AND the OR over all sources of (flag AND enable), using the register values written at that same edge.
- R5: A `take_i` pulse clears the global enable (register 0 bit 7). A `reti_i` pulse sets it. If both arrive together, `take_i` wins, and both override a register-0 write of bit 7. The pin enable is bit 4 of register 0, the timer-0 enable is bit 5 and the port-change enable is bit 3.
- R6: A write that clears the global enable drops `irq_o` at the edge of that write. The pending flags are kept, and `irq_o` returns at the edge that sets the global enable again.
- R7: The pin passes through a two-flop synchronizer. When the edge-select bit (register 3 bit 6) is 1, a rising edge on the pin sets the pin flag. When it is 0, a falling edge sets the pin flag. The flag becomes visible at the third rising clock edge after the pin changes, and an edge of the opposite polarity leaves the flag clear.
- R8: `wake_o` is updated at each edge to `sleep_i` AND the OR over all sources of (flag AND enable). The global enable has no effect on it.
- R9: `vec_o` always shows the vector address 0x0004.
- R10: `rd_o` is registered. It shows, one edge later, the register chosen by `sel_i` as it stood before that edge: 0 selects the core control register, 1 the peripheral flags, 2 the peripheral enables and 3 the option register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| t0_ovf_i | input | 1 | Timer-0 overflow pulse |
| pchg_i | input | 1 | Port-change pulse |
| per_evt_i | input | 5 | Peripheral event pulses (layout as register 1) |
| take_i | input | 1 | Core is taking the interrupt |
| reti_i | input | 1 | Core returns from the interrupt |
| sleep_i | input | 1 | Core is asleep |
| wr_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register select for write and read |
| wdata_i | input | 8 | Write data |
| rd_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake-up request while asleep |
| vec_o | output | 13 | Interrupt vector address |

## Verification
On every cycle the assertions check four things: peripheral events land in their flags, flags never fall without a software write, the global enable follows take and return, and a write that clears the global enable drops the request at once. They also check that wake only appears while asleep. The pin's synchronizer latency, the choice of edge polarity, the way an event wins over a clear in the same cycle, and a wake-up with the global enable clear can only be shown by the bench's directed scenarios. A behavioural model compared on every clock covers the full register mix under random traffic.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DW       = 8;
  localparam int NCORE    = 3;   // port-change, pin, timer-0
  localparam int NPER     = 5;   // cmp0, cmp1, timer-1, eeprom, clock fail
  localparam int GIE_BIT  = 7;
  localparam int EDGE_BIT = 6;
  localparam int CEN_LSB  = 3;
  localparam int PCW      = 13;

  typedef enum logic [1:0] {
    SEL_CORE  = 2'd0,
    SEL_PFLAG = 2'd1,
    SEL_PEN   = 2'd2,
    SEL_OPT   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intc_pin_edge.sv
module intc_pin_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  // sh[SYNC-1] is the synchronized pin, sh[SYNC] its previous value
  logic [SYNC:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], pin_i};
  end

  always_comb begin
    if (rise_sel_i) edge_o = sh[SYNC-1] & ~sh[SYNC];
    else            edge_o = ~sh[SYNC-1] & sh[SYNC];
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         wr_flag_i,
  input  logic [N-1:0] flag_d_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] en_d_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] flag_nx_o,
  output logic [N-1:0] en_nx_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // event set wins over a software clear in the same cycle
    always_comb begin
      flag_nx_o[i] = (wr_flag_i ? flag_d_i[i] : flag_o[i]) | set_i[i];
      en_nx_o[i]   = wr_en_i ? en_d_i[i] : en_o[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_o[i] <= 1'b0;
        en_o[i]   <= 1'b0;
      end else begin
        flag_o[i] <= flag_nx_o[i];
        en_o[i]   <= en_nx_o[i];
      end
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int              SYNC    = 2,
  parameter logic [PCW-1:0]  VEC_ADR = 13'h0004
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pin_i,
  input  logic            t0_ovf_i,
  input  logic            pchg_i,
  input  logic [NPER-1:0] per_evt_i,
  input  logic            take_i,
  input  logic            reti_i,
  input  logic            sleep_i,
  input  logic            wr_i,
  input  logic [1:0]      sel_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rd_o,
  output logic            irq_o,
  output logic            wake_o,
  output logic [PCW-1:0]  vec_o
);
  logic             gie_q, gie_nx;
  logic             edge_sel_q;
  logic             pin_edge;
  logic             wr_core, wr_pflag, wr_pen, wr_opt;
  logic [NCORE-1:0] cflag_q, cen_q, cflag_nx, cen_nx, cset;
  logic [NPER-1:0]  pflag_q, pen_q, pflag_nx, pen_nx;
  logic             pend_nx;
  logic [DW-1:0]    rd_mux;

  assign wr_core  = wr_i && (sel_i == SEL_CORE);
  assign wr_pflag = wr_i && (sel_i == SEL_PFLAG);
  assign wr_pen   = wr_i && (sel_i == SEL_PEN);
  assign wr_opt   = wr_i && (sel_i == SEL_OPT);

  intc_pin_edge #(.SYNC(SYNC)) u_pin (
    .clk(clk), .rst(rst), .pin_i(pin_i),
    .rise_sel_i(edge_sel_q), .edge_o(pin_edge)
  );

  assign cset = {t0_ovf_i, pin_edge, pchg_i};

  intc_bank #(.N(NCORE)) u_core (
    .clk(clk), .rst(rst), .set_i(cset),
    .wr_flag_i(wr_core), .flag_d_i(wdata_i[NCORE-1:0]),
    .wr_en_i(wr_core),   .en_d_i(wdata_i[CEN_LSB +: NCORE]),
    .flag_o(cflag_q), .en_o(cen_q), .flag_nx_o(cflag_nx), .en_nx_o(cen_nx)
  );

  intc_bank #(.N(NPER)) u_per (
    .clk(clk), .rst(rst), .set_i(per_evt_i),
    .wr_flag_i(wr_pflag), .flag_d_i(wdata_i[NPER-1:0]),
    .wr_en_i(wr_pen),     .en_d_i(wdata_i[NPER-1:0]),
    .flag_o(pflag_q), .en_o(pen_q), .flag_nx_o(pflag_nx), .en_nx_o(pen_nx)
  );

  always_comb begin
    if (take_i)       gie_nx = 1'b0;
    else if (reti_i)  gie_nx = 1'b1;
    else if (wr_core) gie_nx = wdata_i[GIE_BIT];
    else              gie_nx = gie_q;
  end

  assign pend_nx = (|(cflag_nx & cen_nx)) | (|(pflag_nx & pen_nx));

  always_comb begin
    rd_mux = '0;
    unique case (reg_sel_e'(sel_i))
      SEL_CORE: begin
        rd_mux[GIE_BIT]              = gie_q;
        rd_mux[CEN_LSB +: NCORE]     = cen_q;
        rd_mux[NCORE-1:0]            = cflag_q;
      end
      SEL_PFLAG: rd_mux[NPER-1:0]    = pflag_q;
      SEL_PEN:   rd_mux[NPER-1:0]    = pen_q;
      SEL_OPT:   rd_mux[EDGE_BIT]    = edge_sel_q;
      default:   rd_mux              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q      <= 1'b0;
      edge_sel_q <= 1'b1;
      irq_o      <= 1'b0;
      wake_o     <= 1'b0;
      rd_o       <= '0;
    end else begin
      gie_q      <= gie_nx;
      if (wr_opt) edge_sel_q <= wdata_i[EDGE_BIT];
      irq_o      <= gie_nx & pend_nx;
      wake_o     <= sleep_i & pend_nx;
      rd_o       <= rd_mux;
    end
  end

  assign vec_o = VEC_ADR;
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [NPER-1:0] per_evt_i,
  input logic            take_i,
  input logic            reti_i,
  input logic            sleep_i,
  input logic            wr_i,
  input logic [1:0]      sel_i,
  input logic [DW-1:0]   wdata_i,
  input logic            irq_o,
  input logic            wake_o,
  input logic [NPER-1:0] pflag_q,
  input logic            gie_q
);
  // R2
  per_set_chk: assert property (@(posedge clk) disable iff (rst)
    (per_evt_i != '0) |=> ((pflag_q & $past(per_evt_i)) == $past(per_evt_i)));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && sel_i == 2'd1) |=> (($past(pflag_q) & ~pflag_q) == '0));

  // R5
  take_clr_chk: assert property (@(posedge clk) disable iff (rst)
    take_i |=> (!gie_q && !irq_o));

  // R5
  reti_set_chk: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !take_i) |=> gie_q);

  // R6
  gie_wr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_i == 2'd0 && !wdata_i[GIE_BIT] && !reti_i) |=> !irq_o);

  // R4
  irq_gie_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> gie_q);

  // R8
  wake_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(sleep_i));
endmodule

bind intc_top intc_chk u_chk (
  .clk(clk), .rst(rst), .per_evt_i(per_evt_i), .take_i(take_i),
  .reti_i(reti_i), .sleep_i(sleep_i), .wr_i(wr_i), .sel_i(sel_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .wake_o(wake_o),
  .pflag_q(pflag_q), .gie_q(gie_q)
);

// File: tb/intc_top_tb.sv
module intc_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0, t0 = 1'b0, pc = 1'b0, take = 1'b0, reti = 1'b0, slp = 1'b0, wr = 1'b0;
  logic [4:0]  pev = '0;
  logic [1:0]  sel = '0;
  logic [7:0]  wd  = '0;
  logic [7:0]  rd;
  logic        irq, wake;
  logic [12:0] vec;

  int errors = 0, checks = 0;
  bit finished = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;  // 125 MHz

  intc_top u_dut (
    .clk(clk), .rst(rst), .pin_i(pin), .t0_ovf_i(t0), .pchg_i(pc),
    .per_evt_i(pev), .take_i(take), .reti_i(reti), .sleep_i(slp),
    .wr_i(wr), .sel_i(sel), .wdata_i(wd), .rd_o(rd), .irq_o(irq),
    .wake_o(wake), .vec_o(vec)
  );

  // behavioural reference model
  int m_gie, m_edge, m_irq, m_wake, m_rd;
  int m_cf[3], m_ce[3], m_pf[5], m_pe[5];
  int p1, p2, p3;

  always @(posedge clk) begin
    int det, any;
    if (rst) begin
      m_gie = 0; m_edge = 1; m_irq = 0; m_wake = 0; m_rd = 0;
      foreach (m_cf[i]) begin m_cf[i] = 0; m_ce[i] = 0; end
      foreach (m_pf[i]) begin m_pf[i] = 0; m_pe[i] = 0; end
      p1 = 0; p2 = 0; p3 = 0;
    end else begin
      case (sel)
        2'd0: m_rd = m_gie * 128 + m_ce[2] * 32 + m_ce[1] * 16 + m_ce[0] * 8
                     + m_cf[2] * 4 + m_cf[1] * 2 + m_cf[0];
        2'd1: begin m_rd = 0; foreach (m_pf[i]) m_rd += m_pf[i] << i; end
        2'd2: begin m_rd = 0; foreach (m_pe[i]) m_rd += m_pe[i] << i; end
        default: m_rd = m_edge * 64;
      endcase
      det = m_edge ? (p2 && !p3) : (!p2 && p3);
      p3 = p2; p2 = p1; p1 = pin;
      if (wr && sel == 2'd0)
        for (int i = 0; i < 3; i++) begin m_cf[i] = wd[i]; m_ce[i] = wd[3+i]; end
      if (wr && sel == 2'd1) foreach (m_pf[i]) m_pf[i] = wd[i];
      if (wr && sel == 2'd2) foreach (m_pe[i]) m_pe[i] = wd[i];
      if (wr && sel == 2'd3) m_edge = wd[6];
      if (pc)  m_cf[0] = 1;
      if (det) m_cf[1] = 1;
      if (t0)  m_cf[2] = 1;
      foreach (m_pf[i]) if (pev[i]) m_pf[i] = 1;
      if (take) m_gie = 0;
      else if (reti) m_gie = 1;
      else if (wr && sel == 2'd0) m_gie = wd[7];
      any = 0;
      foreach (m_cf[i]) if (m_cf[i] && m_ce[i]) any = 1;
      foreach (m_pf[i]) if (m_pf[i] && m_pe[i]) any = 1;
      m_irq  = m_gie && any;
      m_wake = slp && any;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) if (cmp_on && !rst) begin
    chk("R4 irq model", irq, m_irq);
    chk("R8 wake model", wake, m_wake);
    chk("R10 rd model", rd, m_rd);
    chk("R9 vector", vec, 13'h0004);
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wreg(logic [1:0] s, logic [7:0] d);
    wr = 1; sel = s; wd = d; cyc(); wr = 0;
  endtask

  task automatic rreg(logic [1:0] s, output logic [7:0] v);
    sel = s; cyc(); v = rd;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) cyc();
    rst = 0; cmp_on = 1;
    cyc();
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake, 0);
    rreg(2'd0, v); chk("R1 core reg", v, 8'h00);
    rreg(2'd3, v); chk("R1 option reg", v, 8'h40);

    // R2 flag sets with everything masked
    pev = 5'b00100; cyc(); pev = '0;
    rreg(2'd1, v); chk("R2 timer-1 flag", v, 8'h04);
    chk("R2 no irq when masked", irq, 0);
    t0 = 1; pc = 1; cyc(); t0 = 0; pc = 0;
    rreg(2'd0, v); chk("R2 core flags", v, 8'h05);
    wreg(2'd0, 8'h00);

    // R4 request needs both enables
    wreg(2'd2, 8'h04); chk("R4 no irq without global", irq, 0);
    wreg(2'd0, 8'h80); chk("R4 irq asserted", irq, 1);
    chk("R9 vector value", vec, 13'h0004);

    // R5 take and return
    take = 1; cyc(); take = 0;
    chk("R5 take drops irq", irq, 0);
    rreg(2'd0, v); chk("R5 global cleared", v, 8'h00);
    reti = 1; cyc(); reti = 0;
    chk("R5 return restores irq", irq, 1);
    take = 1; reti = 1; cyc(); take = 0; reti = 0;
    chk("R5 take wins over return", irq, 0);
    reti = 1; cyc(); reti = 0;

    // R6 clearing global enable keeps pending
    wreg(2'd0, 8'h00); chk("R6 irq dropped at write", irq, 0);
    rreg(2'd1, v); chk("R6 flag still pending", v, 8'h04);
    wreg(2'd0, 8'h80); chk("R6 irq back", irq, 1);

    // R3 set beats clear, then clear
    pev = 5'b00100; wr = 1; sel = 2'd1; wd = 8'h00; cyc(); wr = 0; pev = '0;
    rreg(2'd1, v); chk("R3 set beats clear", v, 8'h04);
    wreg(2'd1, 8'h00); chk("R3 cleared drops irq", irq, 0);
    rreg(2'd1, v); chk("R3 flag cleared", v, 8'h00);

    // R7 rising edge latency
    wreg(2'd0, 8'h90);
    pin = 1; cyc(); cyc();
    chk("R7 not yet after two edges", irq, 0);
    cyc(); chk("R7 rising sets flag on third edge", irq, 1);
    wreg(2'd0, 8'h90); chk("R7 pin flag cleared", irq, 0);
    wreg(2'd3, 8'h00);
    pin = 0; repeat (3) cyc();
    chk("R7 falling edge detected", irq, 1);
    wreg(2'd0, 8'h90);
    pin = 1; repeat (4) cyc();
    chk("R7 rising ignored in falling mode", irq, 0);
    rreg(2'd0, v); chk("R7 pin flag stays clear", v, 8'h90);

    // R8 wake regardless of global enable
    wreg(2'd0, 8'h00); wreg(2'd2, 8'h01); slp = 1;
    pev = 5'b00001; cyc(); pev = '0;
    chk("R8 wake with global clear", wake, 1);
    chk("R8 no irq", irq, 0);
    slp = 0; cyc(); chk("R8 wake needs sleep", wake, 0);
    wreg(2'd1, 8'h00);

    // random traffic compared with the model
    for (int n = 0; n < 600; n++) begin
      pin  = $urandom_range(0, 3) == 0 ? ~pin : pin;
      t0   = $urandom_range(0, 15) == 0;
      pc   = $urandom_range(0, 15) == 0;
      pev  = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'b0;
      take = $urandom_range(0, 15) == 0;
      reti = $urandom_range(0, 15) == 0;
      slp  = $urandom_range(0, 1);
      wr   = $urandom_range(0, 3) == 0;
      sel  = 2'($urandom);
      wd   = 8'($urandom);
      cyc();
    end
    wr = 0; take = 0; reti = 0; pev = '0; t0 = 0; pc = 0;
    cyc();
    finish_run();
  end
endmodule